// File: doc/BRIEF.md
# Protection Delay Qualifier

This block filters the raw comparator flags of a single-cell battery protection controller. A qualified fault is reported only after its flag has stayed up for a set number of slow timebase ticks. The ticks arrive as a one-cycle enable at roughly 2 kHz, and every channel counts them with its own saturating counter.

There are four fault channels: overcharge (also used for abnormal charge current), overdischarge, overcurrent level 1 and overcurrent level 2. The first three each count while their own flag is held. The level-2 overcurrent counter is different. It is started by the level-1 flag and not by its own flag. Once that count has run out, the level-2 output follows the level-2 flag directly. A severe short can therefore trip well before the level-1 delay ends, as long as level 1 has been present for the short level-2 delay.

All tick counts are parameters, so other delay options can be configured.

Top module: `prot_delay_timer`

## Requirements
- R1: While reset is asserted, and during the two clock cycles after it is released, all four trip outputs are 0 and no counter advances, whatever the flag inputs are.
- R2: With default parameters, the overcharge trip rises on the clock edge that carries the 2000th tick while its flag is held. After 1999 ticks it is still 0.
- R3: With default parameters, the overdischarge trip rises on the 250th tick while its flag is held. After 249 ticks it is still 0.
- R4: With default parameters, the level-1 overcurrent trip rises on the 16th tick while its flag is held. After 15 ticks it is still 0.
- R5: Clock cycles without the tick enable never advance any count.
- R6: Dropping a channel's start flag for a single clock cycle clears its count, so the full delay must be counted again.
- R7: Once tripped, an output stays at 1 while its flag stays high, including through further ticks. It falls in the same cycle that the flag falls.
- R8: The level-2 count starts on the level-1 flag. With the level-1 flag held for 4 ticks, a level-2 flag gives a level-2 trip of 1 while the level-1 trip is still 0.
- R9: A level-2 flag without the level-1 flag never produces a level-2 trip, however many ticks pass.
- R10: After the level-2 count has run out, the level-2 trip follows the level-2 flag with no further delay, as long as the level-1 flag stays high.
- R11: The channels are independent: a flag held on one channel leaves the other trip outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | One-cycle enable from the ~2 kHz timebase |
| ovchg_flag_i | input | 1 | Raw overcharge / abnormal charge flag |
| ovdis_flag_i | input | 1 | Raw overdischarge flag |
| oc1_flag_i | input | 1 | Raw level-1 overcurrent flag |
| oc2_flag_i | input | 1 | Raw level-2 overcurrent flag |
| ovchg_trip_o | output | 1 | Qualified overcharge fault |
| ovdis_trip_o | output | 1 | Qualified overdischarge fault |
| oc1_trip_o | output | 1 | Qualified level-1 overcurrent fault |
| oc2_trip_o | output | 1 | Qualified level-2 overcurrent fault |

## Verification
The hardest situation to reach is a level-2 trip that comes before the level-1 trip. This requires the level-1 flag to be held for a number of ticks between the two delays, with the level-2 flag raised only at that point. The stimulus holds the level-1 flag and issues exactly four tick pulses. It then raises the level-2 flag and observes both trips. After that it toggles the level-2 flag alone, to show that the output now follows the flag with no delay. The one-cycle clear is reached by dropping a flag for a single clock one tick short of saturation.

// File: rtl/prot_delay_pkg.sv
package prot_delay_pkg;
  // default delays in timebase ticks (~2 kHz)
  localparam int unsigned DEF_OVCHG_TICKS = 2000;
  localparam int unsigned DEF_OVDIS_TICKS = 250;
  localparam int unsigned DEF_OC1_TICKS   = 16;
  localparam int unsigned DEF_OC2_TICKS   = 4;
  localparam int unsigned N_DIRECT        = 3;

  typedef enum logic [1:0] {
    CH_OVCHG = 2'd0,
    CH_OVDIS = 2'd1,
    CH_OC1   = 2'd2
  } direct_ch_e;
endpackage

// File: rtl/prot_rst_sync.sv
module prot_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/prot_qual_chan.sv
module prot_qual_chan #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,  // keeps the count running
  input  logic cond_i,   // gated onto the output once saturated
  output logic trip_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sat;

  assign sat = (cnt_q == LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (!start_i)            cnt_d = '0;
    else if (tick_i && !sat) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign trip_o = cond_i & start_i & sat;

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);

  // R5
  step_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q) && cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1 && $past(tick_i)));

  // R6
  clear_on_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> cnt_q == '0);

  // R7
  trip_needs_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |-> (cond_i && start_i));
endmodule

// File: rtl/prot_delay_timer.sv
module prot_delay_timer
  import prot_delay_pkg::*;
#(
  parameter int unsigned OVCHG_TICKS = DEF_OVCHG_TICKS,
  parameter int unsigned OVDIS_TICKS = DEF_OVDIS_TICKS,
  parameter int unsigned OC1_TICKS   = DEF_OC1_TICKS,
  parameter int unsigned OC2_TICKS   = DEF_OC2_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_en_i,
  input  logic ovchg_flag_i,
  input  logic ovdis_flag_i,
  input  logic oc1_flag_i,
  input  logic oc2_flag_i,
  output logic ovchg_trip_o,
  output logic ovdis_trip_o,
  output logic oc1_trip_o,
  output logic oc2_trip_o
);
  localparam int unsigned DIRECT_TICKS [N_DIRECT] = '{OVCHG_TICKS, OVDIS_TICKS, OC1_TICKS};

  logic                rst_n;
  logic [N_DIRECT-1:0] flag_v, trip_v;

  prot_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign flag_v[CH_OVCHG] = ovchg_flag_i;
  assign flag_v[CH_OVDIS] = ovdis_flag_i;
  assign flag_v[CH_OC1]   = oc1_flag_i;

  // channels whose own flag both starts and gates the count
  for (genvar g = 0; g < N_DIRECT; g++) begin : g_direct
    prot_qual_chan #(.TICKS(DIRECT_TICKS[g])) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .tick_i  (tick_en_i),
      .start_i (flag_v[g]),
      .cond_i  (flag_v[g]),
      .trip_o  (trip_v[g])
    );
  end

  // level-2 overcurrent: counting is started by level-1 detection
  prot_qual_chan #(.TICKS(OC2_TICKS)) u_oc2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .tick_i  (tick_en_i),
    .start_i (oc1_flag_i),
    .cond_i  (oc2_flag_i),
    .trip_o  (oc2_trip_o)
  );

  assign ovchg_trip_o = trip_v[CH_OVCHG];
  assign ovdis_trip_o = trip_v[CH_OVDIS];
  assign oc1_trip_o   = trip_v[CH_OC1];

  // R1
  quiet_in_reset_chk: assert property (@(posedge clk_i)
    !rst_n |-> !(ovchg_trip_o || ovdis_trip_o || oc1_trip_o || oc2_trip_o));

  // R9
  oc2_needs_oc1_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    oc2_trip_o |-> oc1_flag_i);

  // R7
  trip_follows_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(ovchg_flag_i) |-> !ovchg_trip_o);
endmodule

// File: tb/tb_prot_delay_timer.sv
module tb_prot_delay_timer;
  logic clk = 1'b0;
  logic rst_n;
  logic tick_en, f_ovchg, f_ovdis, f_oc1, f_oc2;
  logic t_ovchg, t_ovdis, t_oc1, t_oc2;
  int   n_chk = 0;
  int   n_bad = 0;

  always #4 clk = ~clk;

  prot_delay_timer dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick_en_i    (tick_en),
    .ovchg_flag_i (f_ovchg),
    .ovdis_flag_i (f_ovdis),
    .oc1_flag_i   (f_oc1),
    .oc2_flag_i   (f_oc2),
    .ovchg_trip_o (t_ovchg),
    .ovdis_trip_o (t_ovdis),
    .oc1_trip_o   (t_oc1),
    .oc2_trip_o   (t_oc2)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
    end
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic quiet;
    @(negedge clk);
    {f_ovchg, f_ovdis, f_oc1, f_oc2} = 4'b0000;
    idle(2);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tick_en = 1'b1;
    {f_ovchg, f_ovdis, f_oc1, f_oc2} = 4'b1111;
    idle(30);
    check("R1 all trips in reset", t_ovchg | t_ovdis | t_oc1 | t_oc2, 1'b0);
    @(negedge clk) tick_en = 1'b0; {f_ovchg, f_ovdis, f_oc1, f_oc2} = 4'b0000;
    rst_n = 1'b1;
    idle(3);
    check("R1 after release", t_ovchg | t_ovdis | t_oc1 | t_oc2, 1'b0);
  endtask

  task automatic t_ovchg_delay;
    @(negedge clk) f_ovchg = 1'b1;
    ticks(1999);
    check("R2 ovchg at 1999", t_ovchg, 1'b0);
    check("R11 others quiet", t_ovdis | t_oc1 | t_oc2, 1'b0);
    ticks(1);
    check("R2 ovchg at 2000", t_ovchg, 1'b1);
    ticks(5);
    check("R7 ovchg held", t_ovchg, 1'b1);
    @(negedge clk) f_ovchg = 1'b0; #1;
    check("R7 ovchg falls with flag", t_ovchg, 1'b0);
    quiet();
  endtask

  task automatic t_ovdis_delay;
    @(negedge clk) f_ovdis = 1'b1;
    ticks(249);
    check("R3 ovdis at 249", t_ovdis, 1'b0);
    ticks(1);
    check("R3 ovdis at 250", t_ovdis, 1'b1);
    check("R11 others quiet", t_ovchg | t_oc1 | t_oc2, 1'b0);
    quiet();
  endtask

  task automatic t_oc1_and_notick;
    @(negedge clk) f_oc1 = 1'b1;
    ticks(15);
    idle(100);
    check("R5 no advance without tick", t_oc1, 1'b0);
    ticks(1);
    check("R4 oc1 at 16", t_oc1, 1'b1);
    quiet();
  endtask

  task automatic t_clear;
    @(negedge clk) f_oc1 = 1'b1;
    ticks(15);
    @(negedge clk) f_oc1 = 1'b0;
    @(negedge clk) f_oc1 = 1'b1;
    ticks(15);
    check("R6 restart after one-cycle drop", t_oc1, 1'b0);
    ticks(1);
    check("R6 full delay after drop", t_oc1, 1'b1);
    quiet();
  endtask

  task automatic t_chain;
    @(negedge clk) f_oc1 = 1'b1;
    ticks(4);
    @(negedge clk) f_oc2 = 1'b1; #1;
    check("R8 oc2 trips early", t_oc2, 1'b1);
    check("R8 oc1 not yet", t_oc1, 1'b0);
    @(negedge clk) f_oc2 = 1'b0; #1;
    check("R10 oc2 follows flag low", t_oc2, 1'b0);
    @(negedge clk) f_oc2 = 1'b1; #1;
    check("R10 oc2 follows flag high", t_oc2, 1'b1);
    quiet();
    @(negedge clk) f_oc1 = 1'b1; f_oc2 = 1'b1;
    ticks(3);
    check("R8 oc2 before 4 ticks", t_oc2, 1'b0);
    quiet();
  endtask

  task automatic t_oc2_alone;
    @(negedge clk) f_oc2 = 1'b1;
    ticks(40);
    check("R9 oc2 without oc1", t_oc2, 1'b0);
    check("R11 oc1 quiet", t_oc1, 1'b0);
    quiet();
  endtask

  initial begin
    t_reset();
    t_ovchg_delay();
    t_ovdis_delay();
    t_oc1_and_notick();
    t_clear();
    t_chain();
    t_oc2_alone();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule